// File: doc/BRIEF.md
# Triggered Parallel Panel Write Engine

This block sends one frame of pixel words to a command-mode display panel over an 8080-style parallel write bus. It never runs freely. A frame starts only when software issues a trigger through the configuration port, or when the panel raises its tearing-effect line. The block then takes pixels from a valid/ready stream and puts each one on the bus with its own write strobe.

Every bus write cycle is built from four programmable phases, each counted in clock cycles. Chip-select setup comes once, at the start of the frame. Write setup and write hold frame each strobe, and write-active sets the width of the strobe. Chip select stays asserted for the whole frame.

At the end of the frame the block raises an interrupt and stays busy until software acknowledges it. Any trigger that arrives in the meantime is discarded. The divided clock feeding the block must be fast enough to finish a frame before the next tearing-effect pulse, which in practice means at least twice the pixel rate of the frame rate.

Top module: `trig_panel_writer`

## Requirements
- R1: While and after reset, `bus_cs_n` and `bus_wr_n` are 1, `bus_rs`, `frame_irq` and `pix_ready` are 0.
- R2: Each pixel accepted on `pix_valid && pix_ready` produces exactly one low pulse on `bus_wr_n`, in stream order. `bus_data` carries that pixel from the acceptance edge until the end of its hold phase.
- R3: Configuration address 0 is the timing register. Bits 19:16 hold chip-select setup (S), bits 15:12 write setup (W), bits 11:8 write active (A), bits 7:4 write hold (H), and bit 0 is the interface enable. The resulting cycle counts are: `bus_cs_n` fall to first `bus_wr_n` fall is S+1+W; the `bus_wr_n` low width is A; from one `bus_wr_n` rise to the next fall is H+1+W; from the last `bus_wr_n` rise to the `bus_cs_n` rise is H. Reset values are S=W=H=0, A=1, enable=0.
- R4: A write-active field of 0 gives a strobe one cycle wide.
- R5: Configuration address 1 is the trigger register. Bit 0 selects 8080 mode and is stored; bit 1 is a one-shot software trigger and is not stored. A write starts a frame only when the enable is 1 and the written bit 0 is 1. Otherwise the bus stays idle.
- R6: A rising edge on `te_in` starts a frame, after a two-flop synchronizer, when enable and mode are both 1. With either of them 0, the edge is ignored.
- R7: `bus_cs_n` is low without a break from frame start until after the last hold phase. `bus_rs` is 1 exactly while `bus_cs_n` is low, and `bus_wr_n` is low only while `bus_cs_n` is low.
- R8: Configuration address 3, bits 15:0, gives the number of pixels per frame. A value of 0 behaves as 1.
- R9: `frame_irq` rises in the same cycle that `bus_cs_n` rises at the end of a frame. It stays high until a write of 1 to bit 0 of address 2, after which the block is idle on the next cycle.
- R10: Triggers of either kind that arrive during a frame, or while `frame_irq` is high, are dropped and not queued. No frame ever begins without a fresh trigger.
- R11: `pix_ready` is high only between pixels of a running frame. If the stream withholds a pixel, `pix_ready` stays high, `bus_cs_n` stays low and `bus_wr_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (divided panel clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| te_in | input | 1 | Tearing-effect line from the panel (asynchronous) |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream word |
| pix_ready | output | 1 | Pixel stream ready |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_wr_n | output | 1 | Panel write strobe, active low |
| bus_rs | output | 1 | Register/data select, high for pixel data |
| bus_data | output | DATA_W | Panel data bus |
| frame_irq | output | 1 | Frame-done interrupt, pending until cleared |

## Verification
A software trigger written at one rising edge brings `bus_cs_n` low right after that edge. A tearing-effect rise needs three edges to get through the synchronizer and edge detector. A clear of the interrupt drops `frame_irq` one edge after the write. The bench samples every output at the falling clock edge and measures phase lengths as distances between strobe transitions in those samples, so each bound in R3 is checked as an exact cycle count rather than as a wait. Idle checks watch the bus for a fixed window after a trigger that should be ignored, long enough to cover the synchronizer delay.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

    localparam int PH_W   = 4;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_TIMING = 2'd0;
    localparam logic [ADDR_W-1:0] A_TRIG   = 2'd1;
    localparam logic [ADDR_W-1:0] A_IRQ    = 2'd2;
    localparam logic [ADDR_W-1:0] A_LEN    = 2'd3;

    // bit positions inside the timing word
    localparam int CSU_LSB = 16;
    localparam int WSU_LSB = 12;
    localparam int ACT_LSB = 8;
    localparam int HLD_LSB = 4;

    typedef struct packed {
        logic [PH_W-1:0] cs_setup;
        logic [PH_W-1:0] wr_setup;
        logic [PH_W-1:0] wr_active;
        logic [PH_W-1:0] wr_hold;
    } phase_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSU,
        ST_FETCH,
        ST_WSU,
        ST_ACT,
        ST_HOLD,
        ST_DONE
    } seq_st_e;

endpackage

// File: rtl/tpw_cfg_regs.sv
module tpw_cfg_regs
    import tpw_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CFG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              if_en,
    output logic              mode_sel,
    output phase_cfg_t        phase,
    output logic [LEN_W-1:0]  frame_len,
    output logic              sw_start,
    output logic              irq_clear
);

    typedef struct packed {
        logic             en;
        logic             mode;
        phase_cfg_t       ph;
        logic [LEN_W-1:0] len;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        en:   1'b0,
        mode: 1'b0,
        ph:   '{cs_setup: '0, wr_setup: '0, wr_active: PH_W'(1), wr_hold: '0},
        len:  LEN_W'(1)
    };

    regs_t r_d, r_q;

    // parity sink so that data bits without a register behind them stay quiet
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (cfg_addr)
                A_TIMING: begin
                    r_d.en           = cfg_wdata[0];
                    r_d.ph.cs_setup  = cfg_wdata[CSU_LSB +: PH_W];
                    r_d.ph.wr_setup  = cfg_wdata[WSU_LSB +: PH_W];
                    r_d.ph.wr_active = cfg_wdata[ACT_LSB +: PH_W];
                    r_d.ph.wr_hold   = cfg_wdata[HLD_LSB +: PH_W];
                end
                A_TRIG:  r_d.mode = cfg_wdata[0];
                A_LEN:   r_d.len  = cfg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign if_en     = r_q.en;
    assign mode_sel  = r_q.mode;
    assign phase     = r_q.ph;
    assign frame_len = r_q.len;
    // the trigger bit acts only together with the mode bit of the same write
    assign sw_start  = cfg_we && (cfg_addr == A_TRIG) && cfg_wdata[1] && cfg_wdata[0] && r_q.en;
    assign irq_clear = cfg_we && (cfg_addr == A_IRQ) && cfg_wdata[0];

endmodule

// File: rtl/tpw_te_sync.sv
module tpw_te_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic te_in,
    output logic te_rise
);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              last;
    } te_t;

    te_t t_d, t_q;
    logic [SYNC_N-1:0] shifted;

    generate
        if (SYNC_N > 1) begin : g_chain
            assign shifted = {t_q.sync[SYNC_N-2:0], te_in};
        end else begin : g_single
            assign shifted = te_in;
        end
    endgenerate

    always_comb begin
        t_d      = t_q;
        t_d.sync = shifted;
        t_d.last = t_q.sync[SYNC_N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign te_rise = t_q.sync[SYNC_N-1] & ~t_q.last;

endmodule

// File: rtl/tpw_seq.sv
module tpw_seq
    import tpw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              irq_clear,
    input  phase_cfg_t        phase,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rs,
    output logic [DATA_W-1:0] bus_data,
    output logic              frame_irq
);

    typedef struct packed {
        seq_st_e           st;
        logic [PH_W-1:0]   cnt;
        logic [LEN_W-1:0]  npix;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    logic [PH_W-1:0]  act_len;
    logic [LEN_W-1:0] len_eff;
    logic             last_pix;
    logic             pix_fin;
    logic             busy;

    function automatic logic ph_end(input logic [PH_W-1:0] cnt, input logic [PH_W-1:0] len);
        return cnt == (len - PH_W'(1));
    endfunction

    always_comb begin
        s_d      = s_q;
        pix_fin  = 1'b0;
        act_len  = (phase.wr_active == '0) ? PH_W'(1) : phase.wr_active;
        len_eff  = (frame_len == '0) ? LEN_W'(1) : frame_len;
        last_pix = (s_q.npix == (len_eff - LEN_W'(1)));

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = (phase.cs_setup != '0) ? ST_CSU : ST_FETCH;
                    s_d.cnt  = '0;
                    s_d.npix = '0;
                end
            end
            ST_CSU: begin
                if (ph_end(s_q.cnt, phase.cs_setup)) begin
                    s_d.st  = ST_FETCH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            ST_FETCH: begin
                if (pix_valid) begin
                    s_d.data = pix_data;
                    s_d.st   = (phase.wr_setup != '0) ? ST_WSU : ST_ACT;
                    s_d.cnt  = '0;
                end
            end
            ST_WSU: begin
                if (ph_end(s_q.cnt, phase.wr_setup)) begin
                    s_d.st  = ST_ACT;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            ST_ACT: begin
                if (ph_end(s_q.cnt, act_len)) begin
                    s_d.cnt = '0;
                    if (phase.wr_hold != '0) s_d.st = ST_HOLD;
                    else                     pix_fin = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            ST_HOLD: begin
                if (ph_end(s_q.cnt, phase.wr_hold)) begin
                    s_d.cnt = '0;
                    pix_fin = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            ST_DONE: begin
                if (irq_clear) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (pix_fin) begin
            if (last_pix) begin
                s_d.st = ST_DONE;
            end else begin
                s_d.st   = ST_FETCH;
                s_d.npix = s_q.npix + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, npix: '0, data: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE) && (s_q.st != ST_DONE);
    assign bus_cs_n  = ~busy;
    assign bus_rs    = busy;
    assign bus_wr_n  = (s_q.st != ST_ACT);
    assign pix_ready = (s_q.st == ST_FETCH);
    assign frame_irq = (s_q.st == ST_DONE);
    assign bus_data  = s_q.data;

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st inside {ST_WSU, ST_ACT, ST_HOLD}) && ($past(s_q.st) inside {ST_WSU, ST_ACT, ST_HOLD}))
        |-> $stable(bus_data));

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> frame_irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq && !irq_clear) |=> frame_irq);

    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq && irq_clear) |=> (!frame_irq && bus_cs_n));

    // R11
    ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |=> (pix_ready && bus_wr_n && !bus_cs_n));

endmodule

// File: rtl/trig_panel_writer.sv
module trig_panel_writer
    import tpw_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 16,
    parameter int CFG_W   = 32,
    parameter int TE_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              te_in,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rs,
    output logic [DATA_W-1:0] bus_data,
    output logic              frame_irq
);

    logic             if_en;
    logic             mode_sel;
    phase_cfg_t       phase;
    logic [LEN_W-1:0] frame_len;
    logic             sw_start;
    logic             irq_clear;
    logic             te_rise;
    logic             start;

    tpw_cfg_regs #(.LEN_W(LEN_W), .CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .if_en     (if_en),
        .mode_sel  (mode_sel),
        .phase     (phase),
        .frame_len (frame_len),
        .sw_start  (sw_start),
        .irq_clear (irq_clear)
    );

    tpw_te_sync #(.SYNC_N(TE_SYNC)) u_te (
        .clk     (clk),
        .rst_n   (rst_n),
        .te_in   (te_in),
        .te_rise (te_rise)
    );

    // the sequencer only honours start while idle, so busy-time triggers vanish
    assign start = sw_start || (te_rise && if_en && mode_sel);

    tpw_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .irq_clear (irq_clear),
        .phase     (phase),
        .frame_len (frame_len),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .bus_cs_n  (bus_cs_n),
        .bus_wr_n  (bus_wr_n),
        .bus_rs    (bus_rs),
        .bus_data  (bus_data),
        .frame_irq (frame_irq)
    );

endmodule

// File: tb/trig_panel_writer_test.sv
`timescale 1ns/1ps
module trig_panel_writer_test;

    localparam int DW = 16;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          te_in = 1'b0;
    logic          pix_valid = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          pix_ready, bus_cs_n, bus_wr_n, bus_rs, frame_irq;
    logic [DW-1:0] bus_data;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    trig_panel_writer #(.DATA_W(DW), .LEN_W(LW), .CFG_W(32), .TE_SYNC(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .te_in(te_in), .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rs(bus_rs), .bus_data(bus_data),
        .frame_irq(frame_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] tword(input int csu, input int wsu, input int act, input int hld);
        return 32'((csu << 16) | (wsu << 12) | (act << 8) | (hld << 4) | 1);
    endfunction

    task automatic watch_idle(input int n, input string req, input string what);
        int busy_seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (!bus_cs_n || frame_irq) busy_seen++;
        end
        chk(req, what, busy_seen, 0);
    endtask

    // one frame: program, trigger, observe the bus at every falling edge
    task automatic run_frame(input int len, input int csu, input int wsu, input int act, input int hld,
                             input bit stall, input bit use_te, input bit poke, input string tag);
        int len_eff = (len == 0) ? 1 : len;
        int act_exp = (act == 0) ? 1 : act;
        int base = 16'h5A00 + len * 16;
        int cyc = 0, idx = 0, wait_ctr = 0, te_hold = 0;
        int c_fall = -1, r_last = 0, lead = -1, tail = -1, irq_cyc = -1, rise_cyc = -2;
        int gapbad = 0, wbad = 0, wlen = 0, pulses = 0, dbad = 0, rule_bad = 0, stall_seen = 0;
        bit hs_prev = 0, fin = 0;
        logic prev_cs = 1'b1, prev_wr = 1'b1;

        cfg_wr(2'd0, tword(csu, wsu, act, hld));
        cfg_wr(2'd3, 32'(len));
        cfg_wr(2'd1, 32'd1);
        pix_valid = 1'b1;
        pix_data  = DW'(base);
        if (use_te) begin
            te_in = 1'b1; te_hold = 3;
        end else begin
            cfg_wr(2'd1, 32'd3);
        end

        while (!fin && cyc < 3000) begin
            if (prev_cs && !bus_cs_n) c_fall = cyc;
            if (!bus_cs_n && !bus_rs) rule_bad++;
            if (bus_cs_n && (bus_rs || !bus_wr_n)) rule_bad++;
            if (prev_wr && !bus_wr_n) begin
                if (pulses == 0) lead = cyc - c_fall;
                else if (!stall && (cyc - r_last) != hld + 1 + wsu) gapbad++;
                wlen = 0;
            end
            if (!bus_wr_n) begin
                wlen++;
                if (bus_data !== DW'(base + pulses)) dbad++;
            end
            if (!prev_wr && bus_wr_n) begin
                pulses++; r_last = cyc;
                if (wlen != act_exp) wbad++;
            end
            if (!prev_cs && bus_cs_n) begin
                tail = cyc - r_last; rise_cyc = cyc;
            end
            if (pix_ready && !pix_valid) begin
                stall_seen++;
                if (bus_cs_n || !bus_wr_n) rule_bad++;
            end
            if (frame_irq) begin
                irq_cyc = cyc; fin = 1;
            end
            prev_cs = bus_cs_n;
            prev_wr = bus_wr_n;

            // pixel source
            if (hs_prev) begin
                idx++;
                if (stall) begin
                    pix_valid = 1'b0; wait_ctr = 3;
                end else begin
                    pix_valid = (idx < len_eff); pix_data = DW'(base + idx);
                end
            end else if (wait_ctr > 0) begin
                wait_ctr--;
                if (wait_ctr == 0) begin
                    pix_valid = (idx < len_eff); pix_data = DW'(base + idx);
                end
            end
            hs_prev = pix_valid && pix_ready;

            if (te_hold > 0) begin
                te_hold--;
                if (te_hold == 0) te_in = 1'b0;
            end
            // R10: extra triggers in the middle of the frame
            if (poke && cyc == 4) begin
                cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'd3;
            end else if (poke && cyc == 5) begin
                cfg_we = 1'b0; te_in = 1'b1;
            end else if (poke && cyc == 9) begin
                te_in = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        te_in = 1'b0; pix_valid = 1'b0; cfg_we = 1'b0;

        chk("R2", {tag, " strobe count"}, pulses, len_eff);
        chk("R2", {tag, " data mismatches"}, dbad, 0);
        chk("R3", {tag, " cs to first strobe"}, lead, csu + 1 + wsu);
        chk("R3", {tag, " strobe spacing errors"}, gapbad, 0);
        chk("R3", {tag, " last strobe to cs release"}, tail, hld);
        if (act == 0) chk("R4", {tag, " zero-field width errors"}, wbad, 0);
        else          chk("R3", {tag, " strobe width errors"}, wbad, 0);
        chk("R7", {tag, " cs/rs/wr rule violations"}, rule_bad, 0);
        chk("R9", {tag, " irq cycle vs cs release"}, irq_cyc, rise_cyc);
        if (stall) chk("R11", {tag, " stall cycles seen"}, int'(stall_seen > 0), 1);

        if (poke) begin
            cfg_wr(2'd1, 32'd3);
            chk("R10", {tag, " trigger while pending keeps irq"}, int'(frame_irq), 1);
            chk("R10", {tag, " trigger while pending keeps cs high"}, int'(bus_cs_n), 1);
        end
        cfg_wr(2'd2, 32'd1);
        chk("R9", {tag, " irq after clear"}, int'(frame_irq), 0);
        chk("R9", {tag, " cs after clear"}, int'(bus_cs_n), 1);
        if (poke) watch_idle(40, "R10", {tag, " dropped triggers started nothing"});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "cs_n in reset", int'(bus_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs_n", int'(bus_cs_n), 1);
        chk("R1", "wr_n", int'(bus_wr_n), 1);
        chk("R1", "rs", int'(bus_rs), 0);
        chk("R1", "irq", int'(frame_irq), 0);
        chk("R1", "ready", int'(pix_ready), 0);
    endtask

    task automatic t_gating;
        cfg_wr(2'd0, tword(0, 0, 1, 0));
        cfg_wr(2'd3, 32'd2);
        cfg_wr(2'd1, 32'd2);              // R5: trigger without the mode bit
        watch_idle(30, "R5", "trigger without mode");
        cfg_wr(2'd0, 32'h0000_0100);      // enable cleared
        cfg_wr(2'd1, 32'd3);
        watch_idle(30, "R5", "trigger while disabled");
        @(negedge clk); te_in = 1'b1;     // R6: TE with enable 0, mode 1
        repeat (3) @(negedge clk); te_in = 1'b0;
        watch_idle(30, "R6", "TE while disabled");
        cfg_wr(2'd0, tword(0, 0, 1, 0));
        cfg_wr(2'd1, 32'd0);
        @(negedge clk); te_in = 1'b1;     // R6: TE with mode 0
        repeat (3) @(negedge clk); te_in = 1'b0;
        watch_idle(30, "R6", "TE without mode");
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        run_frame(3, 0, 0, 1, 0, 1'b0, 1'b0, 1'b0, "plain");     // R2 R3 R7 R9
        run_frame(4, 2, 3, 4, 2, 1'b0, 1'b0, 1'b1, "timed");     // R3 R10
        run_frame(2, 1, 0, 0, 1, 1'b0, 1'b0, 1'b0, "act0");      // R4
        run_frame(2, 0, 0, 1, 0, 1'b0, 1'b1, 1'b0, "te");        // R6
        run_frame(3, 0, 1, 2, 0, 1'b1, 1'b0, 1'b0, "stall");     // R11
        run_frame(0, 1, 1, 1, 1, 1'b0, 1'b0, 1'b0, "len0");      // R8
        t_gating();                                              // R5 R6
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule